// File: doc/BRIEF.md
# Modulator Bitstream Sample Strobe Generator

This block turns the clock and data lines of an external sigma-delta style modulator into sample events in the system clock domain. A source selector chooses which clock drives the sampling. The choices are one of several external clock pins or a clock generated on chip by dividing the system clock. A data selector chooses one of two data pins, taken directly or inverted, or forces the data to zero when the input is disconnected.

A strobe mode chooses the clock edges that take a sample: rising edges, falling edges, both edges, or every second rising or falling edge. Every external line first passes a two-flop synchronizer. Edges are found by comparing consecutive synchronized levels. On each qualifying edge the block raises `strobe` for one system cycle, and in that same cycle it presents the freshly captured bit on `sample_bit` for the filter downstream.

Top module: `mbs_strobe_gen`

## Requirements
- R1: Strobe mode codes 0, 4 and 7 never raise `strobe`, whatever the clock does.
- R2: In mode 1, a rising level change on the selected external clock pin raises `strobe` for exactly one cycle. It is high during the third system cycle after the change is applied between clock edges.
- R3: In mode 2, a falling level change on the selected external clock pin raises `strobe` with the same timing as R2, and a rising change raises nothing.
- R4: In mode 3, both rising and falling changes of the selected clock raise `strobe`.
- R5: Mode 5 strobes on every second rising edge and mode 6 on every second falling edge. The first qualifying edge after reset or after a configuration change gives no strobe, and the second one does.
- R6: Data select codes are: 2 = pin A, 3 = pin A inverted, 4 = pin B, 5 = pin B inverted, and 0, 1, 6, 7 = disconnected (bit 0). `sample_bit` takes the selected value in the same cycle `strobe` is high.
- R7: `sample_bit` holds its value in every cycle where `strobe` is low, even when the data pins change.
- R8: Clock select codes 0 to 3 pick external clock pins 0 to 3. Code 4 picks the internal clock, which toggles every INT_HALF system cycles (default 4). Codes 5 to 7 select no clock and never strobe. Edges on unselected pins have no effect.
- R9: A change of clock select or strobe mode never raises `strobe` by itself in the cycle it takes effect, and it restarts the every-second-edge divider.
- R10: While reset is asserted, `strobe` and `sample_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_clk | input | N_CLK_IN | External modulator clock pins, asynchronous |
| data_a | input | 1 | Modulator data pin A, asynchronous |
| data_b | input | 1 | Modulator data pin B, asynchronous |
| clk_sel | input | SEL_W | Clock source code (R8) |
| data_sel | input | 3 | Data source code (R6) |
| strobe_mode | input | 3 | Strobe edge pattern code (R1 to R5) |
| strobe | output | 1 | One-cycle sample trigger |
| sample_bit | output | 1 | Data bit captured with the latest strobe |

## Verification
If the previous-level register were wrong, it would show as a missing or extra strobe in the third cycle after a clock change. A wrong synchronizer depth would shift that pulse by a cycle. A divider phase that fails to restart after a configuration change makes the very first qualifying edge strobe instead of the second, so it shows within two edges. A data path fault shows on `sample_bit` at the same strobe cycle, or as a change of that output while `strobe` is low. The internal clock's divide ratio is visible as the spacing between consecutive strobes within a few periods.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef logic [2:0] smode_t;
  typedef logic [2:0] dsel_t;

  localparam smode_t SM_NONE  = 3'd0;
  localparam smode_t SM_RISE  = 3'd1;
  localparam smode_t SM_FALL  = 3'd2;
  localparam smode_t SM_BOTH  = 3'd3;
  localparam smode_t SM_RISE2 = 3'd5;
  localparam smode_t SM_FALL2 = 3'd6;

  localparam dsel_t DS_A     = 3'd2;
  localparam dsel_t DS_A_INV = 3'd3;
  localparam dsel_t DS_B     = 3'd4;
  localparam dsel_t DS_B_INV = 3'd5;

  // Selected data value; unlisted codes read as disconnected (0).
  function automatic logic pick_data(input dsel_t sel, input logic a, input logic b);
    logic v;
    case (sel)
      DS_A:     v = a;
      DS_A_INV: v = ~a;
      DS_B:     v = b;
      DS_B_INV: v = ~b;
      default:  v = 1'b0;
    endcase
    return v;
  endfunction

  function automatic logic mode_active(input smode_t m);
    return (m == SM_RISE) || (m == SM_FALL) || (m == SM_BOTH) ||
           (m == SM_RISE2) || (m == SM_FALL2);
  endfunction

  function automatic logic mode_divided(input smode_t m);
    return (m == SM_RISE2) || (m == SM_FALL2);
  endfunction

endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mbs_int_clk.sv
module mbs_int_clk #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic lvl
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tog_q, tog_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    tog_d = wrap ? ~tog_q : tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign lvl = tog_q;
endmodule

// File: rtl/mbs_edge_sel.sv
module mbs_edge_sel
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl,
  input  smode_t mode,
  input  logic   cfg_chg,
  output logic   fire
);
  logic prev_q;
  logic phase_q, phase_d;
  logic rise, fall, hit, div;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    case (mode)
      SM_RISE, SM_RISE2: hit = rise;
      SM_FALL, SM_FALL2: hit = fall;
      SM_BOTH:           hit = rise | fall;
      default:           hit = 1'b0;
    endcase
    div  = mode_divided(mode);
    fire = ~cfg_chg & hit & (~div | phase_q);
    if (cfg_chg)        phase_d = 1'b0;
    else if (hit & div) phase_d = ~phase_q;
    else                phase_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/mbs_strobe_gen.sv
module mbs_strobe_gen
  import mbs_pkg::*;
#(
  parameter int N_CLK_IN    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int INT_HALF    = 4,
  parameter int SEL_W       = $clog2(N_CLK_IN + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CLK_IN-1:0] mod_clk,
  input  logic                data_a,
  input  logic                data_b,
  input  logic [SEL_W-1:0]    clk_sel,
  input  logic [2:0]          data_sel,
  input  logic [2:0]          strobe_mode,
  output logic                strobe,
  output logic                sample_bit
);
  localparam int              IDX_W    = $clog2(N_CLK_IN);
  localparam int              BUS_W    = N_CLK_IN + 2;
  localparam logic [SEL_W-1:0] INT_CODE = SEL_W'(N_CLK_IN);

  logic [BUS_W-1:0]    bus_s;
  logic [N_CLK_IN-1:0] clk_s;
  logic                da_s, db_s;
  logic                int_lvl;
  logic                sel_lvl;
  logic                cfg_chg;
  logic                fire;
  logic                bit_d;

  logic [SEL_W-1:0] clk_sel_q;
  smode_t           mode_q;
  logic             strobe_q;
  logic             bit_q;

  mbs_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({data_b, data_a, mod_clk}),
    .q    (bus_s)
  );

  assign clk_s = bus_s[N_CLK_IN-1:0];
  assign da_s  = bus_s[N_CLK_IN];
  assign db_s  = bus_s[N_CLK_IN+1];

  mbs_int_clk #(.HALF(INT_HALF)) u_int_clk (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (int_lvl)
  );

  always_comb begin
    sel_lvl = 1'b0;
    if (clk_sel < INT_CODE)       sel_lvl = clk_s[clk_sel[IDX_W-1:0]];
    else if (clk_sel == INT_CODE) sel_lvl = int_lvl;
    cfg_chg = (clk_sel != clk_sel_q) || (strobe_mode != mode_q);
    bit_d   = pick_data(data_sel, da_s, db_s);
  end

  mbs_edge_sel u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (sel_lvl),
    .mode   (strobe_mode),
    .cfg_chg(cfg_chg),
    .fire   (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_q <= '0;
      mode_q    <= SM_NONE;
      strobe_q  <= 1'b0;
    end else begin
      clk_sel_q <= clk_sel;
      mode_q    <= strobe_mode;
      strobe_q  <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bit_q <= 1'b0;
    else if (fire) bit_q <= bit_d;
  end

  assign strobe     = strobe_q;
  assign sample_bit = bit_q;
endmodule

// File: rtl/mbs_strobe_chk.sv
module mbs_strobe_chk #(
  parameter int SEL_W    = 3,
  parameter int INT_CODE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] clk_sel,
  input logic [2:0]       data_sel,
  input logic [2:0]       strobe_mode,
  input logic             strobe,
  input logic             sample_bit
);
  logic [1:0] armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed <= '0;
    else if (armed != 2'd3)  armed <= armed + 2'd1;
  end

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed != 2'd0 && !mbs_pkg::mode_active($past(strobe_mode))) |-> !strobe); // R1

  AST_DISC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed != 2'd0 && strobe && ($past(data_sel) < 3'd2 || $past(data_sel) > 3'd5))
      |-> !sample_bit); // R6

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed != 2'd0 && !strobe) |-> $stable(sample_bit)); // R7

  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed != 2'd0 && $past(clk_sel) > SEL_W'(INT_CODE)) |-> !strobe); // R8

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == 2'd3 && ($past(clk_sel) != $past(clk_sel, 2) ||
                       $past(strobe_mode) != $past(strobe_mode, 2))) |-> !strobe); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_LOW: assert (!strobe && !sample_bit); // R10
    end
  end
endmodule

bind mbs_strobe_gen mbs_strobe_chk #(.SEL_W(SEL_W), .INT_CODE(N_CLK_IN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_sel    (clk_sel),
  .data_sel   (data_sel),
  .strobe_mode(strobe_mode),
  .strobe     (strobe),
  .sample_bit (sample_bit)
);

// File: tb/mbs_strobe_gen_test.sv
module mbs_strobe_gen_test;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mclk;
  logic       da, db;
  logic [2:0] csel, dsel, smode;
  logic       strobe, sample_bit;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  phase_m = 0;
  bit  exp_bit = 0;

  always #2 clk = ~clk;

  mbs_strobe_gen #(.INT_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .mod_clk(mclk), .data_a(da), .data_b(db),
    .clk_sel(csel), .data_sel(dsel), .strobe_mode(smode),
    .strobe(strobe), .sample_bit(sample_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ref_data(input logic [2:0] s, input bit a, input bit b);
    case (s)
      3'd2: return a;
      3'd3: return ~a;
      3'd4: return b;
      3'd5: return ~b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R1";
    endcase
  endfunction

  // Called at a negedge; ends at a negedge after 4 quiet cycles.
  task automatic set_cfg(input logic [2:0] c, input logic [2:0] d, input logic [2:0] m);
    int seen = 0;
    if (c != csel || m != smode) phase_m = 0;
    csel = c; dsel = d; smode = m;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (strobe) seen++;
    end
    chk(seen == 0, "R9 config change strobe count", seen, 0);
  endtask

  task automatic do_edge(input int line, input bit lvl, input bit a, input bit b);
    bit    fire = 0;
    bit    hit;
    int    pat = 0;
    int    exp_pat;
    string req;
    req = (csel == 3'(line)) ? mode_req(smode) : "R8";
    if (csel == 3'(line) && mclk[line] != lvl) begin
      case (smode)
        3'd1, 3'd5: hit = lvl;
        3'd2, 3'd6: hit = ~lvl;
        3'd3:       hit = 1;
        default:    hit = 0;
      endcase
      if (smode == 3'd5 || smode == 3'd6) begin
        if (hit) begin
          fire = phase_m;
          phase_m = ~phase_m;
        end
      end else fire = hit;
    end
    mclk[line] = lvl; da = a; db = b;
    if (fire) exp_bit = ref_data(dsel, a, b);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (strobe) pat |= (1 << k);
    end
    exp_pat = fire ? (1 << 3) : 0;
    chk(pat == exp_pat, {req, " strobe cycle pattern"}, pat, exp_pat);
    chk(sample_bit == exp_bit, fire ? "R6 captured bit" : "R7 held bit",
        int'(sample_bit), int'(exp_bit));
  endtask

  task automatic measure_gap(input int gap_exp, input string req);
    int last = -1;
    int gaps = 0;
    for (int t = 0; t < 80; t++) begin
      @(negedge clk);
      if (strobe) begin
        if (last >= 0) begin
          chk(t - last == gap_exp, {req, " internal clock strobe spacing"}, t - last, gap_exp);
          gaps++;
        end
        last = t;
      end
    end
    chk(gaps >= 2, {req, " internal clock strobes seen"}, gaps, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    rst_n = 0; mclk = '0; da = 0; db = 0; csel = 0; dsel = 0; smode = 0;
    repeat (3) @(negedge clk);
    chk(!strobe && !sample_bit, "R10 reset outputs", int'({strobe, sample_bit}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2: rising edges, pin A direct
    set_cfg(3'd0, 3'd2, 3'd1);
    do_edge(0, 1, 1, 0);
    do_edge(0, 0, 0, 0);
    do_edge(0, 1, 0, 1);
    // R3: falling, pin B inverted
    set_cfg(3'd0, 3'd5, 3'd2);
    do_edge(0, 0, 1, 0);
    do_edge(0, 1, 1, 1);
    // R7: data changes without an edge
    do_edge(1, 1, 0, 1);
    // R4 both edges
    set_cfg(3'd0, 3'd3, 3'd3);
    do_edge(0, 0, 0, 0);
    do_edge(0, 1, 1, 0);
    // R1 modes without strobe
    set_cfg(3'd0, 3'd2, 3'd4);
    do_edge(0, 0, 1, 1);
    do_edge(0, 1, 1, 1);
    set_cfg(3'd0, 3'd2, 3'd7);
    do_edge(0, 0, 0, 0);
    // R9: switching from a high pin to a low pin in falling mode
    set_cfg(3'd0, 3'd2, 3'd2);
    do_edge(0, 1, 1, 0);
    do_edge(2, 0, 1, 0);
    set_cfg(3'd2, 3'd2, 3'd2);
    // R5 divider restart on configuration change
    set_cfg(3'd0, 3'd4, 3'd5);
    do_edge(0, 0, 0, 1);
    do_edge(0, 1, 0, 1);
    set_cfg(3'd1, 3'd4, 3'd5);
    set_cfg(3'd0, 3'd4, 3'd5);
    do_edge(0, 0, 0, 0);
    do_edge(0, 1, 0, 0);
    do_edge(0, 0, 0, 1);
    do_edge(0, 1, 0, 1);
    // R8 no clock source
    set_cfg(3'd6, 3'd2, 3'd3);
    for (int i = 0; i < 4; i++) do_edge(i, ~mclk[i], 1, 1);
    // R8 internal clock spacing
    set_cfg(3'd4, 3'd2, 3'd1);
    measure_gap(2 * HALF, "R8");
    set_cfg(3'd4, 3'd2, 3'd3);
    measure_gap(HALF, "R4");
    set_cfg(3'd4, 3'd2, 3'd6);
    measure_gap(4 * HALF, "R5");

    // Random configurations and edges
    set_cfg(3'd0, 3'd0, 3'd0);
    for (int r = 0; r < 40; r++) begin
      set_cfg(3'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
      for (int e = 0; e < 8; e++) begin
        int ln;
        ln = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : int'(csel);
        do_edge(ln, ~mclk[ln], 1'($urandom), 1'($urandom));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule